// File: doc/BRIEF.md
# Delay Outlier Corrector

After read-centering calibration, a few per-bit read delays may land far below their neighbours. This block takes one rank pair, reads every delay field of that pair through a single-outstanding register port, and finds the median of the values it collected. Any field whose value is no greater than a chosen percentage of that median is then replaced with the median. Registers are only touched where a correction is due. Each correction is a fresh read, a field substitution and a write-back, so every other bit of the word keeps its value.

A run starts with a one-cycle `start`. When it ends, `done` pulses for one cycle. At that point `err`, `median` and `fixCount` hold the outcome of the run, and they keep it until the next start. With `featureEn` low the block finishes at once and leaves the register space alone.

Top module: `delay_outlier_fix`

## Requirements
- R1: After reset `done`, `err` and `regReq` are 0. Each run produces exactly one `done` pulse, one cycle wide.
- R2: When `start` arrives with `featureEn` low, `done` pulses by the second cycle after start with `err`=0 and `median`=`fixCount`=0, and no register access takes place.
- R3: A `rankPair` of 4 or more gives `done` with `err`=1, and no register is read or written.
- R4: Register k (0..35) of pair p sits at address p*36+k. Its even field occupies bits [55:49] and its odd field bits [63:57]. One run reads all 36 registers, which yields 72 values, value 2k being even and 2k+1 being odd.
- R5: `median` is the element at index 36 of the 72 values sorted in ascending order. For an even split this is the upper of the two middle values.
- R6: The threshold is floor(pct*median/100). A `percent` input of 0 selects the default of 66.
- R7: A field whose value is less than or equal to the threshold is rewritten with the median. A field that is strictly above the threshold keeps its value.
- R8: A correction re-reads the register and then writes it back. Bits outside the corrected fields are preserved. Registers with nothing to correct, and all registers of other pairs, are never written.
- R9: `regReq` stays high with stable `regAddr` and `regWe` until `regAck`. At most one transaction is outstanding.
- R10: `fixCount` counts the corrected fields. When both fields of one register qualify, they are corrected by a single write and add 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (one-cycle pulse) |
| featureEn | input | 1 | Correction enabled |
| rankPair | input | 3 | Rank pair to process |
| percent | input | 8 | Threshold percentage, 0 selects 66 |
| regReq | output | 1 | Register transaction request |
| regWe | output | 1 | 1 = write, 0 = read |
| regAddr | output | 8 | Register address |
| regWdata | output | 64 | Write data |
| regAck | input | 1 | Transaction complete, read data valid |
| regRdata | input | 64 | Read data |
| done | output | 1 | Run finished (pulse) |
| err | output | 1 | Invalid rank pair on last run |
| median | output | 7 | Median found on last run |
| fixCount | output | 7 | Fields corrected on last run |

## Verification
A register whose even and odd fields both fall under the threshold has to be handled by one read-modify-write that substitutes both fields in the same cycle. That write must also advance the count by two in that cycle. The bench provokes this with low value pairs placed in one register: one case uses a single such register among normal values, and another puts half of all registers at a low value. Each case is judged against a reference word image built from the preserved bits. The bench also checks that the write total equals the number of affected registers, not the number of fields, and that `fixCount` equals the number of fields.

// File: rtl/dof_pkg.sv
package dof_pkg;

  typedef struct packed {
    logic clear;
    logic capture;
    logic scanEn;
    logic holdCap;
    logic countAdd;
  } dof_strobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_GATHER, S_SCAN, S_CHECK, S_FIX_RD, S_FIX_WR, S_DONE
  } dof_state_t;

endpackage

// File: rtl/dof_dpath.sv
module dof_dpath
  import dof_pkg::*;
#(
  parameter int N       = 72,
  parameter int FW      = 7,
  parameter int DW      = 64,
  parameter int EO      = 49,
  parameter int OO      = 57,
  parameter int PCT_W   = 8,
  parameter int DEF_PCT = 66,
  parameter int RIDX_W  = 6,
  parameter int CNT_W   = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dof_strobe_t       stb,
  input  logic [RIDX_W-1:0] idx,
  input  logic [DW-1:0]     rdData,
  input  logic [PCT_W-1:0]  pct,
  output logic              medFound,
  output logic              needFix,
  output logic [FW-1:0]     median,
  output logic [CNT_W-1:0]  fixCount,
  output logic [DW-1:0]     wrData
);
  localparam int IDX_W = $clog2(N);
  localparam int PW    = PCT_W + FW;
  localparam logic [CNT_W:0] HALF    = (CNT_W+1)'(N / 2);
  localparam logic [PW-1:0]  HUNDRED = PW'(100);

  logic [FW-1:0]    vals [N];
  logic [IDX_W-1:0] evenPos, oddPos, scanI, scanJ;
  logic [CNT_W-1:0] lessCnt, eqCnt;
  logic [CNT_W:0]   lessNext, eqNext;
  logic [DW-1:0]    holdR;
  logic [PW-1:0]    thr, prod;
  logic [PCT_W-1:0] pctEff;
  logic             found, fixEven, fixOdd;
  logic [FW-1:0]    candV, cmpV;

  assign evenPos = IDX_W'({idx, 1'b0});
  assign oddPos  = IDX_W'({idx, 1'b1});

  // value buffer, filled while gathering
  always_ff @(posedge clk) begin
    if (stb.capture) begin
      vals[evenPos] <= rdData[EO +: FW];
      vals[oddPos]  <= rdData[OO +: FW];
    end
  end

  // rank-counting median search: candidate scanI against every scanJ
  assign candV    = vals[scanI];
  assign cmpV     = vals[scanJ];
  assign lessNext = (CNT_W+1)'(lessCnt) + (CNT_W+1)'(cmpV < candV);
  assign eqNext   = (CNT_W+1)'(eqCnt) + (CNT_W+1)'(cmpV == candV);
  assign found    = (lessNext <= HALF) && (HALF < lessNext + eqNext);

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      scanI <= '0; scanJ <= '0; lessCnt <= '0; eqCnt <= '0;
      medFound <= 1'b0; median <= '0;
    end else if (stb.scanEn && !medFound) begin
      if (scanJ == IDX_W'(N - 1)) begin
        if (found) begin
          median   <= candV;
          medFound <= 1'b1;
        end else begin
          scanI <= scanI + 1'b1;
        end
        scanJ <= '0; lessCnt <= '0; eqCnt <= '0;
      end else begin
        scanJ   <= scanJ + 1'b1;
        lessCnt <= lessNext[CNT_W-1:0];
        eqCnt   <= eqNext[CNT_W-1:0];
      end
    end
  end

  // threshold and per-register correction decision
  assign pctEff  = (pct == '0) ? PCT_W'(DEF_PCT) : pct;
  assign prod    = PW'(pctEff) * PW'(median);
  assign thr     = prod / HUNDRED;
  assign fixEven = PW'(vals[evenPos]) <= thr;
  assign fixOdd  = PW'(vals[oddPos]) <= thr;
  assign needFix = fixEven | fixOdd;

  always_ff @(posedge clk) begin
    if (!rstN) holdR <= '0;
    else if (stb.holdCap) holdR <= rdData;
  end

  always_comb begin
    wrData = holdR;
    if (fixEven) wrData[EO +: FW] = median;
    if (fixOdd)  wrData[OO +: FW] = median;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) fixCount <= '0;
    else if (stb.countAdd) fixCount <= fixCount + CNT_W'(fixEven) + CNT_W'(fixOdd);
  end

  p_fields_written_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.countAdd |-> ((wrData[EO +: FW] == median) || (PW'(wrData[EO +: FW]) > thr)) &&
                     ((wrData[OO +: FW] == median) || (PW'(wrData[OO +: FW]) > thr)));
  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    fixCount <= CNT_W'(N));
  p_median_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    (medFound && $past(medFound)) |-> $stable(median));

endmodule

// File: rtl/dof_ctrl.sv
module dof_ctrl
  import dof_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int REGS      = 36,
  parameter int PAIR_W    = 3,
  parameter int ADDR_W    = 8,
  parameter int RIDX_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              featureEn,
  input  logic [PAIR_W-1:0] rankPair,
  input  logic              medFound,
  input  logic              needFix,
  input  logic              regAck,
  output logic              regReq,
  output logic              regWe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [RIDX_W-1:0] idx,
  output dof_strobe_t       stb,
  output logic              done,
  output logic              err
);
  localparam logic [RIDX_W-1:0] LAST = RIDX_W'(REGS - 1);

  dof_state_t        state;
  logic [ADDR_W-1:0] base;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; idx <= '0; err <= 1'b0; base <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          err <= 1'b0;
          idx <= '0;
          if (!featureEn) begin
            state <= S_DONE;
          end else if (rankPair >= PAIR_W'(NUM_PAIRS)) begin
            err   <= 1'b1;
            state <= S_DONE;
          end else begin
            base  <= ADDR_W'(rankPair) * ADDR_W'(REGS);
            state <= S_GATHER;
          end
        end
        S_GATHER: if (regAck) begin
          if (idx == LAST) begin idx <= '0; state <= S_SCAN; end
          else idx <= idx + 1'b1;
        end
        S_SCAN: if (medFound) state <= S_CHECK;
        S_CHECK: begin
          if (needFix) state <= S_FIX_RD;
          else if (idx == LAST) state <= S_DONE;
          else idx <= idx + 1'b1;
        end
        S_FIX_RD: if (regAck) state <= S_FIX_WR;
        S_FIX_WR: if (regAck) begin
          if (idx == LAST) state <= S_DONE;
          else begin idx <= idx + 1'b1; state <= S_CHECK; end
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb          = '0;
    stb.clear    = (state == S_IDLE) && start;
    stb.capture  = (state == S_GATHER) && regAck;
    stb.scanEn   = (state == S_SCAN);
    stb.holdCap  = (state == S_FIX_RD) && regAck;
    stb.countAdd = (state == S_FIX_WR) && regAck;
  end

  assign regReq  = (state == S_GATHER) || (state == S_FIX_RD) || (state == S_FIX_WR);
  assign regWe   = (state == S_FIX_WR);
  assign regAddr = base + ADDR_W'(idx);
  assign done    = (state == S_DONE);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regAck) |=> (regReq && $stable(regAddr) && $stable(regWe)));
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_no_access_err_r3: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !regReq);

endmodule

// File: rtl/delay_outlier_fix.sv
module delay_outlier_fix
  import dof_pkg::*;
#(
  parameter int NUM_PAIRS     = 4,
  parameter int REGS_PER_PAIR = 36,
  parameter int FIELD_W       = 7,
  parameter int DATA_W        = 64,
  parameter int EVEN_LSB      = 49,
  parameter int ODD_LSB       = 57,
  parameter int PCT_W         = 8,
  parameter int DEFAULT_PCT   = 66,
  localparam int N            = 2 * REGS_PER_PAIR,
  localparam int CNT_W        = $clog2(N + 1),
  localparam int ADDR_W       = $clog2(NUM_PAIRS * REGS_PER_PAIR),
  localparam int PAIR_W       = $clog2(NUM_PAIRS) + 1,
  localparam int RIDX_W       = $clog2(REGS_PER_PAIR)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               featureEn,
  input  logic [PAIR_W-1:0]  rankPair,
  input  logic [PCT_W-1:0]   percent,
  output logic               regReq,
  output logic               regWe,
  output logic [ADDR_W-1:0]  regAddr,
  output logic [DATA_W-1:0]  regWdata,
  input  logic               regAck,
  input  logic [DATA_W-1:0]  regRdata,
  output logic               done,
  output logic               err,
  output logic [FIELD_W-1:0] median,
  output logic [CNT_W-1:0]   fixCount
);
  dof_strobe_t       stb;
  logic [RIDX_W-1:0] idx;
  logic              medFound, needFix;

  dof_ctrl #(
    .NUM_PAIRS(NUM_PAIRS), .REGS(REGS_PER_PAIR), .PAIR_W(PAIR_W),
    .ADDR_W(ADDR_W), .RIDX_W(RIDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .featureEn(featureEn),
    .rankPair(rankPair), .medFound(medFound), .needFix(needFix),
    .regAck(regAck), .regReq(regReq), .regWe(regWe), .regAddr(regAddr),
    .idx(idx), .stb(stb), .done(done), .err(err)
  );

  dof_dpath #(
    .N(N), .FW(FIELD_W), .DW(DATA_W), .EO(EVEN_LSB), .OO(ODD_LSB),
    .PCT_W(PCT_W), .DEF_PCT(DEFAULT_PCT), .RIDX_W(RIDX_W), .CNT_W(CNT_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .idx(idx), .rdData(regRdata),
    .pct(percent), .medFound(medFound), .needFix(needFix),
    .median(median), .fixCount(fixCount), .wrData(regWdata)
  );

endmodule

// File: tb/delay_outlier_fix_bench.sv
`timescale 1ns/1ps
module delay_outlier_fix_bench;
  localparam int NP = 4, REGS = 36, NV = 72, EO = 49, OO = 57, NW = NP * REGS;

  logic        clk = 0, rstN = 0, start = 0, featureEn = 0;
  logic [2:0]  rankPair = 0;
  logic [7:0]  percent = 0;
  logic        regReq, regWe, regAck = 0, done, err;
  logic [7:0]  regAddr;
  logic [63:0] regWdata, regRdata = 0;
  logic [6:0]  median, fixCount;

  always #4 clk = ~clk;

  delay_outlier_fix u_delay_outlier_fix (
    .clk(clk), .rstN(rstN), .start(start), .featureEn(featureEn),
    .rankPair(rankPair), .percent(percent), .regReq(regReq), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regAck(regAck), .regRdata(regRdata),
    .done(done), .err(err), .median(median), .fixCount(fixCount)
  );

  logic [63:0] mem [NW];
  logic [63:0] snap [NW];
  int tv [NV];
  int nChk = 0, nFail = 0;
  int rdCnt = 0, wrCnt = 0, hsErr = 0, lat = 0, wcnt = 0;
  logic        waitReq = 0, waitWe = 0;
  logic [7:0]  waitAddr = 0;

  // register responder, acts on the falling edge
  always @(negedge clk) begin
    if (waitReq && (!regReq || regAddr != waitAddr || regWe != waitWe)) hsErr++;
    if (regAck) begin
      regAck = 0;
    end else if (regReq) begin
      if (wcnt >= lat) begin
        wcnt = 0;
        regAck = 1;
        if (regWe) begin mem[regAddr] = regWdata; wrCnt++; end
        else begin regRdata = mem[regAddr]; rdCnt++; end
      end else wcnt++;
    end
    waitReq  = regReq && !regAck;
    waitAddr = regAddr;
    waitWe   = regWe;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic loadPair(input int pair);
    for (int r = 0; r < REGS; r++) begin
      logic [63:0] w;
      w = {$urandom, $urandom};
      w[EO +: 7] = 7'(tv[2*r]);
      w[OO +: 7] = 7'(tv[2*r+1]);
      mem[pair*REGS + r] = w;
    end
    for (int a = 0; a < NW; a++) snap[a] = mem[a];
  endtask

  task automatic runOp(input int pair, input int pct, input bit en, output int cyc);
    @(negedge clk);
    rankPair = 3'(pair); percent = 8'(pct); featureEn = en; start = 1;
    rdCnt = 0; wrCnt = 0; hsErr = 0;
    @(negedge clk);
    start = 0; cyc = 1;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(done, "R1 done seen", done, 1);
    @(negedge clk);
    chk(!done, "R1 done is a single pulse", done, 0);
  endtask

  task automatic checkUntouched(input string tag);
    int bad = 0;
    for (int a = 0; a < NW; a++) if (mem[a] !== snap[a]) bad++;
    chk(bad == 0 && rdCnt == 0 && wrCnt == 0, tag, bad + rdCnt + wrCnt, 0);
  endtask

  // reference model built from the requirements
  task automatic checkRun(input int pair, input int pct, input string name);
    int s [NV];
    int med, pe, thr, cnt, fixRegs, bad, other;
    for (int k = 0; k < NV; k++) s[k] = tv[k];
    for (int a = 1; a < NV; a++) begin
      int v = s[a]; int b = a - 1;
      while (b >= 0 && s[b] > v) begin s[b+1] = s[b]; b--; end
      s[b+1] = v;
    end
    med = s[NV/2];
    pe  = (pct == 0) ? 66 : pct;
    thr = (pe * med) / 100;
    cnt = 0; fixRegs = 0; bad = 0; other = 0;
    for (int r = 0; r < REGS; r++) begin
      logic [63:0] w;
      bit fe, fo;
      w  = snap[pair*REGS + r];
      fe = tv[2*r] <= thr;
      fo = tv[2*r+1] <= thr;
      if (fe) w[EO +: 7] = 7'(med);
      if (fo) w[OO +: 7] = 7'(med);
      cnt += int'(fe) + int'(fo);
      if (fe || fo) fixRegs++;
      if (mem[pair*REGS + r] !== w) bad++;
    end
    for (int a = 0; a < NW; a++)
      if ((a / REGS) != pair && mem[a] !== snap[a]) other++;
    chk(err == 0, {name, " R3 no error on valid pair"}, err, 0);
    chk(median == 7'(med), {name, " R5 median"}, median, med);
    chk(fixCount == 7'(cnt), {name, " R10 corrected field count"}, fixCount, cnt);
    chk(bad == 0, {name, " R7 field values after correction"}, bad, 0);
    chk(other == 0, {name, " R8 other pairs untouched"}, other, 0);
    chk(wrCnt == fixRegs, {name, " R8 R10 one write per affected register"}, wrCnt, fixRegs);
    chk(rdCnt == REGS + fixRegs, {name, " R4 R8 reads gather plus re-read"}, rdCnt, REGS + fixRegs);
    chk(hsErr == 0, {name, " R9 request held stable until ack"}, hsErr, 0);
  endtask

  task automatic tReset();
    chk(!done && !err && !regReq, "R1 reset state", {done, err, regReq}, 0);
  endtask

  task automatic tDisabled();
    int c;
    for (int k = 0; k < NV; k++) tv[k] = 50;
    tv[0] = 1;
    loadPair(0);
    runOp(0, 66, 0, c);
    chk(c <= 2, "R2 prompt done when disabled", c, 2);
    chk(!err && median == 0 && fixCount == 0, "R2 clean outputs when disabled", {err, median, fixCount}, 0);
    checkUntouched("R2 no register access when disabled");
  endtask

  task automatic tBadPair();
    int c;
    runOp(4, 66, 1, c);
    chk(err == 1, "R3 error on pair 4", err, 1);
    checkUntouched("R3 no access on pair 4");
    runOp(7, 66, 1, c);
    chk(err == 1, "R3 error on pair 7", err, 1);
    checkUntouched("R3 no access on pair 7");
  endtask

  task automatic tNormal();
    int c;
    for (int k = 0; k < NV; k++) tv[k] = 45 + int'($urandom % 20);
    tv[6] = 3; tv[7] = 9;        // both fields of register 3
    tv[20] = 30; tv[51] = 12;
    lat = 2;
    loadPair(1);
    runOp(1, 66, 1, c);
    checkRun(1, 66, "normal");
    lat = 0;
  endtask

  task automatic tBoundary();
    int c;
    for (int k = 0; k < NV; k++) tv[k] = 60;
    tv[0] = 30; tv[3] = 31; tv[10] = 29;
    loadPair(0);
    runOp(0, 50, 1, c);
    checkRun(0, 50, "boundary");
    chk(fixCount == 2, "R7 equal fixed, one above kept", fixCount, 2);
  endtask

  task automatic tTruncate();
    int c;
    for (int k = 0; k < NV; k++) tv[k] = 61;
    tv[4] = 40; tv[5] = 41;
    loadPair(3);
    runOp(3, 66, 1, c);
    checkRun(3, 66, "truncate");
    chk(fixCount == 1, "R6 truncated threshold 40", fixCount, 1);
  endtask

  task automatic tDefaultPct();
    int c;
    for (int k = 0; k < NV; k++) tv[k] = 61;
    tv[8] = 40; tv[9] = 41;
    lat = 1;
    loadPair(2);
    runOp(2, 0, 1, c);
    checkRun(2, 0, "default");
    chk(fixCount == 1, "R6 percent 0 selects 66", fixCount, 1);
    lat = 0;
  endtask

  task automatic tUpperMedian();
    int c;
    for (int k = 0; k < NV; k++) tv[k] = (k < NV/2) ? 10 : 50;
    loadPair(1);
    runOp(1, 66, 1, c);
    checkRun(1, 66, "upper");
    chk(median == 50, "R5 upper middle on even split", median, 50);
  endtask

  task automatic tNoFix();
    int c;
    for (int k = 0; k < NV; k++) tv[k] = 25;
    loadPair(2);
    runOp(2, 66, 1, c);
    checkRun(2, 66, "nofix");
    chk(wrCnt == 0, "R8 no writes when nothing qualifies", wrCnt, 0);
  endtask

  initial begin
    for (int a = 0; a < NW; a++) mem[a] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1;
    @(negedge clk);
    tReset();
    tDisabled();
    tBadPair();
    tNormal();
    tBoundary();
    tTruncate();
    tDefaultPct();
    tUpperMedian();
    tNoFix();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule